// File: doc/BRIEF.md
# Poison-Bit Deferred Exception Register File

This block is an integer register file for a core whose compiler hoists instructions above branches. Each register stores a data word plus one poison flag. An instruction marked speculative never raises an exception when it executes. If it would have faulted, its destination is written with the poison flag set. A speculative result computed from a poisoned operand inherits the flag. The fault becomes a real exception only when an explicit check names a poisoned register, or when a non-speculative instruction tries to consume one.

Two combinational read ports supply operands. The single write port carries the destination, the data, a speculative tag, a fault-pending flag, and two flags that say which read ports feed the instruction being written back. A check port asks whether one register is poisoned. A bulk-clear input wipes every poison flag at once so that recovery code can start clean. Exceptions leave the block as a registered one-cycle pulse that carries a register index and a cause code.

Top module: `poison_rf`

## Requirements
- R1: After reset every register reads data 0 with its poison flag clear, and `exc_valid` is 0.
- R2: A non-speculative write without a pending fault, none of whose used sources is poisoned, stores `wr_data` and clears the destination's poison flag. Both are visible on the read ports from the next cycle.
- R3: A speculative write with `wr_fault` high stores `wr_data`, sets the destination's poison flag and raises no exception.
- R4: A speculative write sets the destination's poison flag when a read port marked as used (`wr_use_a` / `wr_use_b`) returns a poisoned register. With no fault and no poisoned used source, the flag is cleared.
- R5: A check on a poisoned register pulses `exc_valid` in the next cycle with `exc_idx` equal to `chk_idx` and `exc_cause` = 2'b01. A check on a clean register raises nothing.
- R6: A non-speculative write that has a poisoned used source leaves the file unchanged. In the next cycle it raises `exc_cause` = 2'b10, with `exc_idx` set to the read-A index when port A is used and poisoned, and to the read-B index otherwise.
- R7: A non-speculative write with `wr_fault` high leaves the file unchanged. In the next cycle it raises `exc_cause` = 2'b11 with `exc_idx` equal to `wr_idx`.
- R8: At most one exception is reported per cycle. A non-speculative fault (2'b11) takes priority over a poisoned source (2'b10), which takes priority over a check (2'b01).
- R9: `exc_valid` is a single-cycle pulse. It is 0 in any cycle that follows a cycle with neither a write nor a check.
- R10: `clr_poison` clears every poison flag at the next edge. A write in the same cycle is applied after the clear, so its poison value survives.
- R11: The poison flag on a read port whose use flag is low has no effect on the write or on exceptions.
- R12: The read ports and the check return the state from before the current cycle's write. There is no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | IDX_W | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_a_poison | output | 1 | Read port A poison flag |
| rd_b_idx | input | IDX_W | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data |
| rd_b_poison | output | 1 | Read port B poison flag |
| wr_en | input | 1 | Write-back request |
| wr_idx | input | IDX_W | Destination register |
| wr_data | input | DATA_W | Result data |
| wr_spec | input | 1 | Instruction is speculative |
| wr_fault | input | 1 | Instruction would have faulted |
| wr_use_a | input | 1 | Write's instruction consumed read port A |
| wr_use_b | input | 1 | Write's instruction consumed read port B |
| chk_en | input | 1 | Check request |
| chk_idx | input | IDX_W | Register to check |
| clr_poison | input | 1 | Clear all poison flags |
| exc_valid | output | 1 | Exception pulse |
| exc_idx | output | IDX_W | Register tied to the exception |
| exc_cause | output | 2 | 01 check, 10 poisoned source, 11 fault |

## Verification
Read data and read poison are combinational on the current state, so the bench compares them one nanosecond after it drives the indices, before the edge that applies that cycle's write. That timing covers R12. Exceptions pass through one register, so the pulse for a stimulus driven in cycle n is sampled a quarter period after edge n+1, and every check is set against the model's state from before that edge. Writes and clears become visible on the reads driven in the following cycle, and the bench updates its model only after the read comparison for the current cycle.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_CHECK  = 2'b01,
        CAUSE_POISON = 2'b10,
        CAUSE_FAULT  = 2'b11
    } exc_cause_e;

endpackage

// File: rtl/prf_store.sv
module prf_store #(
    parameter int NREG   = 128,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [IDX_W-1:0]  c_idx,
    output logic [DATA_W-1:0] a_data,
    output logic [DATA_W-1:0] b_data,
    output logic              a_pois,
    output logic              b_pois,
    output logic              c_pois,
    input  logic              commit,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_pois,
    input  logic              clr_all
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] data;
        logic [NREG-1:0]             pois;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.pois = '0;
        end
        if (commit) begin
            st_d.data[w_idx] = w_data;
            st_d.pois[w_idx] = w_pois;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_data = st_q.data[a_idx];
    assign b_data = st_q.data[b_idx];
    assign a_pois = st_q.pois[a_idx];
    assign b_pois = st_q.pois[b_idx];
    assign c_pois = st_q.pois[c_idx];

endmodule

// File: rtl/prf_wrctl.sv
module prf_wrctl
    import poison_rf_pkg::*;
#(
    parameter int NREG   = 128,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             wr_en,
    input  logic             wr_spec,
    input  logic             wr_fault,
    input  logic             use_a,
    input  logic             use_b,
    input  logic             a_pois,
    input  logic             b_pois,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [IDX_W-1:0] w_idx,
    output logic             commit,
    output logic             commit_pois,
    output logic             wexc_valid,
    output exc_cause_e       wexc_cause,
    output logic [IDX_W-1:0] wexc_idx
);

    logic a_hit, b_hit;

    assign a_hit = use_a && a_pois;
    assign b_hit = use_b && b_pois;

    always_comb begin
        commit      = 1'b0;
        commit_pois = 1'b0;
        wexc_valid  = 1'b0;
        wexc_cause  = CAUSE_NONE;
        wexc_idx    = '0;
        if (wr_en) begin
            if (wr_spec) begin
                commit      = 1'b1;
                commit_pois = wr_fault || a_hit || b_hit;
            end else if (wr_fault) begin
                wexc_valid = 1'b1;
                wexc_cause = CAUSE_FAULT;
                wexc_idx   = w_idx;
            end else if (a_hit) begin
                wexc_valid = 1'b1;
                wexc_cause = CAUSE_POISON;
                wexc_idx   = a_idx;
            end else if (b_hit) begin
                wexc_valid = 1'b1;
                wexc_cause = CAUSE_POISON;
                wexc_idx   = b_idx;
            end else begin
                commit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prf_excgen.sv
module prf_excgen
    import poison_rf_pkg::*;
#(
    parameter int NREG   = 128,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wexc_valid,
    input  exc_cause_e       wexc_cause,
    input  logic [IDX_W-1:0] wexc_idx,
    input  logic             chk_en,
    input  logic             chk_pois,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             exc_valid,
    output logic [1:0]       exc_cause,
    output logic [IDX_W-1:0] exc_idx
);

    typedef struct packed {
        logic             valid;
        exc_cause_e       cause;
        logic [IDX_W-1:0] idx;
    } exc_t;

    exc_t ex_d, ex_q;

    always_comb begin
        ex_d = '{valid: 1'b0, cause: CAUSE_NONE, idx: '0};
        if (wexc_valid) begin
            ex_d = '{valid: 1'b1, cause: wexc_cause, idx: wexc_idx};
        end else if (chk_en && chk_pois) begin
            ex_d = '{valid: 1'b1, cause: CAUSE_CHECK, idx: chk_idx};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '{valid: 1'b0, cause: CAUSE_NONE, idx: '0};
        end else begin
            ex_q <= ex_d;
        end
    end

    assign exc_valid = ex_q.valid;
    assign exc_cause = ex_q.cause;
    assign exc_idx   = ex_q.idx;

endmodule

// File: rtl/poison_rf.sv
module poison_rf
    import poison_rf_pkg::*;
#(
    parameter int NREG   = 128,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_spec,
    input  logic              wr_fault,
    input  logic              wr_use_a,
    input  logic              wr_use_b,
    input  logic              chk_en,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic              clr_poison,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_idx,
    output logic [1:0]        exc_cause
);

    logic             chk_pois;
    logic             commit, commit_pois;
    logic             wexc_valid;
    exc_cause_e       wexc_cause;
    logic [IDX_W-1:0] wexc_idx;

    prf_store #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (rd_a_idx),
        .b_idx   (rd_b_idx),
        .c_idx   (chk_idx),
        .a_data  (rd_a_data),
        .b_data  (rd_b_data),
        .a_pois  (rd_a_poison),
        .b_pois  (rd_b_poison),
        .c_pois  (chk_pois),
        .commit  (commit),
        .w_idx   (wr_idx),
        .w_data  (wr_data),
        .w_pois  (commit_pois),
        .clr_all (clr_poison)
    );

    prf_wrctl #(.NREG(NREG)) u_wrctl (
        .wr_en       (wr_en),
        .wr_spec     (wr_spec),
        .wr_fault    (wr_fault),
        .use_a       (wr_use_a),
        .use_b       (wr_use_b),
        .a_pois      (rd_a_poison),
        .b_pois      (rd_b_poison),
        .a_idx       (rd_a_idx),
        .b_idx       (rd_b_idx),
        .w_idx       (wr_idx),
        .commit      (commit),
        .commit_pois (commit_pois),
        .wexc_valid  (wexc_valid),
        .wexc_cause  (wexc_cause),
        .wexc_idx    (wexc_idx)
    );

    prf_excgen #(.NREG(NREG)) u_exc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wexc_valid (wexc_valid),
        .wexc_cause (wexc_cause),
        .wexc_idx   (wexc_idx),
        .chk_en     (chk_en),
        .chk_pois   (chk_pois),
        .chk_idx    (chk_idx),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause),
        .exc_idx    (exc_idx)
    );

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int NREG   = 128,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_poison,
    input logic              rd_b_poison,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_spec,
    input logic              wr_fault,
    input logic              wr_use_a,
    input logic              wr_use_b,
    input logic              chk_en,
    input logic              chk_pois,
    input logic              clr_poison,
    input logic              exc_valid,
    input logic [IDX_W-1:0]  exc_idx,
    input logic [1:0]        exc_cause
);

    // R9: no request in a cycle means no pulse in the next one
    a_r9_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || chk_en) |=> !exc_valid);

    // R3: a speculative write on its own never raises anything
    a_r3_spec_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_spec && !chk_en) |=> !exc_valid);

    // R5: checking a clean register with no write raises nothing
    a_r5_clean_check: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !chk_pois && !wr_en) |=> !exc_valid);

    // R7: a non-speculative fault reports its destination with cause 11
    a_r7_fault_report: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_spec && wr_fault) |=>
            (exc_valid && exc_cause == 2'b11 && exc_idx == $past(wr_idx)));

    // R10: a clear with no write leaves both read ports unpoisoned
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_poison && !wr_en) |=> (!rd_a_poison && !rd_b_poison));

    // R2: a clean non-speculative write is visible and unpoisoned
    a_r2_clean_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_spec && !wr_fault && !(wr_use_a && rd_a_poison)
            && !(wr_use_b && rd_b_poison)) |=>
            ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data) && !rd_a_poison)));

endmodule

bind poison_rf prf_checker #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_a_poison (rd_a_poison),
    .rd_b_poison (rd_b_poison),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .wr_spec     (wr_spec),
    .wr_fault    (wr_fault),
    .wr_use_a    (wr_use_a),
    .wr_use_b    (wr_use_b),
    .chk_en      (chk_en),
    .chk_pois    (chk_pois),
    .clr_poison  (clr_poison),
    .exc_valid   (exc_valid),
    .exc_idx     (exc_idx),
    .exc_cause   (exc_cause)
);

// File: tb/sim_poison_rf.sv
module sim_poison_rf;

    localparam int NREG   = 128;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(NREG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, chk_idx = '0;
    logic [DATA_W-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic              rd_a_poison, rd_b_poison;
    logic              wr_en = 0, wr_spec = 0, wr_fault = 0, wr_use_a = 0, wr_use_b = 0;
    logic              chk_en = 0, clr_poison = 0;
    logic              exc_valid;
    logic [IDX_W-1:0]  exc_idx;
    logic [1:0]        exc_cause;

    int total = 0, bad = 0;
    bit done = 0;

    logic [DATA_W-1:0] mdata [NREG];
    logic              mpois [NREG];

    always #10 clk = ~clk;

    poison_rf #(.NREG(NREG), .DATA_W(DATA_W)) u0 (.*);

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit en, input bit spec, input bit flt,
                        input bit ua, input bit ub, input int wi, input logic [DATA_W-1:0] wd,
                        input int ai, input int bi, input bit ce, input int ci, input bit clr);
        bit ev; logic [1:0] ec; int ei; bit pa, pb;
        @(negedge clk);
        wr_en = en; wr_spec = spec; wr_fault = flt; wr_use_a = ua; wr_use_b = ub;
        wr_idx = IDX_W'(wi); wr_data = wd; rd_a_idx = IDX_W'(ai); rd_b_idx = IDX_W'(bi);
        chk_en = ce; chk_idx = IDX_W'(ci); clr_poison = clr;
        #1;
        chk(tag, "rd_a_data", 64'(rd_a_data), 64'(mdata[ai]));
        chk(tag, "rd_a_poison", 64'(rd_a_poison), 64'(mpois[ai]));
        chk(tag, "rd_b_data", 64'(rd_b_data), 64'(mdata[bi]));
        chk(tag, "rd_b_poison", 64'(rd_b_poison), 64'(mpois[bi]));
        pa = ua && mpois[ai]; pb = ub && mpois[bi];
        ev = 0; ec = 2'b00; ei = 0;
        if (en && !spec && flt) begin ev = 1; ec = 2'b11; ei = wi; end
        else if (en && !spec && pa) begin ev = 1; ec = 2'b10; ei = ai; end
        else if (en && !spec && pb) begin ev = 1; ec = 2'b10; ei = bi; end
        else if (ce && mpois[ci]) begin ev = 1; ec = 2'b01; ei = ci; end
        if (clr) for (int k = 0; k < NREG; k++) mpois[k] = 1'b0;
        if (en && spec) begin mdata[wi] = wd; mpois[wi] = flt || pa || pb; end
        else if (en && !ev) begin mdata[wi] = wd; mpois[wi] = 1'b0; end
        else if (en && ev && ec == 2'b01) begin mdata[wi] = wd; mpois[wi] = 1'b0; end
        @(posedge clk); #5;
        chk(tag, "exc_valid", 64'(exc_valid), 64'(ev));
        if (ev) begin
            chk(tag, "exc_cause", 64'(exc_cause), 64'(ec));
            chk(tag, "exc_idx", 64'(exc_idx), 64'(ei));
        end
    endtask

    task automatic idle(input string tag, input int ai, input int bi);
        step(tag, 0, 0, 0, 0, 0, 0, '0, ai, bi, 0, 0, 0);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            bad++; total++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NREG; k++) begin mdata[k] = '0; mpois[k] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        #5 chk("R1", "exc_valid", 64'(exc_valid), 64'd0);
        idle("R1", 0, 127);
        idle("R1", 64, 5);
        // R2 clean non-speculative write, then read back
        step("R2", 1, 0, 0, 0, 0, 5, 32'hA5A5_0005, 1, 2, 0, 0, 0);
        idle("R2", 5, 5);
        // R3 speculative faulting write
        step("R3", 1, 1, 1, 0, 0, 6, 32'h0000_0666, 0, 0, 0, 0, 0);
        idle("R3", 6, 5);
        // R4 propagation through used port A
        step("R4", 1, 1, 0, 1, 0, 7, 32'h77, 6, 5, 0, 0, 0);
        idle("R4", 7, 6);
        // R11 unused poisoned source is ignored
        step("R11", 1, 1, 0, 0, 1, 8, 32'h88, 0, 7, 0, 0, 0);
        step("R11", 1, 0, 0, 1, 0, 12, 32'hCC, 5, 7, 0, 0, 0);
        idle("R11", 8, 12);
        // R5 check poisoned and clean
        step("R5", 0, 0, 0, 0, 0, 0, '0, 7, 8, 1, 7, 0);
        step("R5", 0, 0, 0, 0, 0, 0, '0, 7, 8, 1, 5, 0);
        // R6 non-speculative consumer of poison via B, then via A and B
        step("R6", 1, 0, 0, 0, 1, 9, 32'h99, 5, 7, 0, 0, 0);
        step("R6", 1, 0, 0, 1, 1, 9, 32'h99, 6, 7, 0, 0, 0);
        idle("R6", 9, 9);
        // R7 non-speculative fault
        step("R7", 1, 0, 1, 0, 0, 10, 32'hAA, 6, 7, 0, 0, 0);
        idle("R7", 10, 10);
        // R8 priorities
        step("R8", 1, 0, 1, 1, 0, 11, 32'hBB, 6, 7, 1, 7, 0);
        step("R8", 1, 0, 0, 1, 0, 11, 32'hBB, 6, 7, 1, 7, 0);
        step("R8", 1, 1, 1, 0, 0, 11, 32'hBB, 6, 7, 1, 7, 0);
        // R9 pulse falls
        idle("R9", 11, 6);
        // R12 no bypass: write and read same register in one cycle
        step("R12", 1, 0, 0, 0, 0, 13, 32'hDD, 13, 13, 0, 0, 0);
        step("R12", 1, 1, 1, 0, 0, 13, 32'hDE, 13, 13, 1, 13, 0);
        step("R12", 0, 0, 0, 0, 0, 0, '0, 13, 13, 1, 13, 0);
        // R10 clear plus same-cycle poisoned write
        step("R10", 1, 1, 1, 0, 0, 14, 32'hEE, 6, 7, 0, 0, 1);
        idle("R10", 14, 6);
        idle("R10", 7, 11);
        // random mix
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 3000; n++) begin
            int wi, ai, bi, ci;
            wi = ($urandom % 16 == 0) ? 127 : int'($urandom % 8);
            ai = int'($urandom % 8); bi = int'($urandom % 8); ci = int'($urandom % 8);
            step("R4 R6 R8", $urandom % 3 != 0, $urandom % 2 == 1, $urandom % 4 == 0,
                 $urandom % 2 == 1, $urandom % 2 == 1, wi, $urandom, ai, bi,
                 $urandom % 3 == 0, ci, $urandom % 40 == 0);
        end
        idle("R9", 127, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule